// File: doc/BRIEF.md
# Trap Entry Privileged-State Updater

This block holds the processor-state word, the hypervisor-state word and the global register level of a processor core. When the core takes a trap, it rewrites all three in one step. A one-cycle trap-take strobe comes with a two-bit trap kind. On the next clock edge the block replaces the stored words with their trap-entry values. Three kinds of trap are handled:

- **Recovery-state trap.** The processor-state word is wiped except for one bit.
- **Trap into privileged mode.** Selected bits are set or cleared, and one bit copies its neighbour.
- **Trap into hyperprivileged mode.** The privilege bit is kept, and the hypervisor word switches its mode bits.

The global level steps up by one on every real trap and stops at a configurable ceiling.

A synchronous load port lets the surrounding core, or a bench, overwrite the stored state at any time. The block has a single decision point: which of reset, load, trap or hold applies on a clock edge. The combinational next-state path dispatches on the trap kind with these named cases:

- `TK_NONE` (code 00): hold.
- `TK_RED` (code 01): recovery rewrite.
- `TK_PRIV` (code 10): privileged rewrite.
- `TK_HYP` (code 11): hyperprivileged rewrite.

The transitions are reset → cleared, load → loaded values, trap with a kind other than none → rewritten values, and anything else → hold.

Top module: `trap_state_unit`

## Requirements
- R1: When `rst` is high at a rising clock edge, `pstate`, `hpstate` and `gl` all become zero after that edge, even if `load_en` or `trap_take` is also high.
- R2: When `trap_take` is high with `trap_kind` 01, 10 or 11 and `load_en` is low, `gl` after the edge equals the old `gl` plus one. If the old `gl` is greater than or equal to `GL_MAX` (default 6), `gl` becomes `GL_MAX` instead.
- R3: For a trap with kind 01 (recovery), the new `pstate` is all zero except two bits. Bit 2 keeps its old value and bit 4 is 1.
- R4: For a trap with kind 01, `hpstate` bit 5 becomes 1 and every other `hpstate` bit is unchanged.
- R5: For a trap with kind 10 or 11, `pstate` bit 4 becomes 1 and bits 3 and 1 become 0. Bits 0, 5, 6, 7, 8 and 10 through 15 keep their old values.
- R6: For a trap with kind 11 (hyperprivileged), `pstate` bit 9 becomes 0 and bit 2 keeps its old value.
- R7: For a trap with kind 11, `hpstate` bits 5 and 10 become 0 and bit 2 becomes 1. All other `hpstate` bits are unchanged.
- R8: For a trap with kind 10 (privileged), `pstate` bit 2 becomes 1, `pstate` bit 9 takes the old value of `pstate` bit 8, and `hpstate` is unchanged.
- R9: A `trap_take` pulse with `trap_kind` 00 leaves `pstate`, `hpstate` and `gl` unchanged.
- R10: When `load_en` is high (and `rst` is low), `pstate`, `hpstate` and `gl` take `load_pstate`, `load_hpstate` and `load_gl` after the edge. This holds even when `trap_take` is high in the same cycle.
- R11: With `rst`, `load_en` and `trap_take` all low, the three outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Overwrite stored state from the load inputs |
| load_pstate | input | PS_W (16) | Processor-state value to load |
| load_hpstate | input | HS_W (16) | Hypervisor-state value to load |
| load_gl | input | GL_W (3) | Global level to load |
| trap_take | input | 1 | One-cycle strobe: take a trap of kind `trap_kind` |
| trap_kind | input | 2 | 00 none, 01 recovery, 10 privileged, 11 hyperprivileged |
| pstate | output | PS_W (16) | Stored processor-state word |
| hpstate | output | HS_W (16) | Stored hypervisor-state word |
| gl | output | GL_W (3) | Stored global level |

## Verification
The bound checker evaluates every clock edge. It compares each output with its previous value under the trap, load or idle condition in force: the recovery, privileged and hyperprivileged bit rewrites, the saturating level step, load priority, and holding when no event occurs. The clearing effect of reset, and the fact that reset overrides a simultaneous load, are shown only by the bench's reset scenario. The bench also drives several random starting states through each trap kind and compares all three outputs against its own model. It pushes the level to and beyond its ceiling, including loaded values above the ceiling, which only directed scenarios can set up.

// File: rtl/tsu_pkg.sv
package tsu_pkg;

    typedef enum logic [1:0] {
        TK_NONE = 2'b00,
        TK_RED  = 2'b01,
        TK_PRIV = 2'b10,
        TK_HYP  = 2'b11
    } trap_kind_e;

    // processor-state bit positions
    localparam int PS_IE   = 1;
    localparam int PS_PRIV = 2;
    localparam int PS_AM   = 3;
    localparam int PS_PEF  = 4;
    localparam int PS_TLE  = 8;
    localparam int PS_CLE  = 9;

    // hypervisor-state bit positions
    localparam int HS_HPRIV = 2;
    localparam int HS_RED   = 5;
    localparam int HS_IBE   = 10;

endpackage

// File: rtl/tsu_pstate_rewrite.sv
module tsu_pstate_rewrite
    import tsu_pkg::*;
#(
    parameter int PS_W = 16
) (
    input  trap_kind_e        kind,
    input  logic [PS_W-1:0]   ps_old,
    output logic [PS_W-1:0]   ps_new
);

    always_comb begin
        ps_new = ps_old;
        unique case (kind)
            TK_NONE: ps_new = ps_old;
            TK_RED: begin
                ps_new          = '0;
                ps_new[PS_PRIV] = ps_old[PS_PRIV];
                ps_new[PS_PEF]  = 1'b1;
            end
            TK_PRIV: begin
                ps_new[PS_PEF]  = 1'b1;
                ps_new[PS_AM]   = 1'b0;
                ps_new[PS_IE]   = 1'b0;
                ps_new[PS_PRIV] = 1'b1;
                ps_new[PS_CLE]  = ps_old[PS_TLE];
            end
            TK_HYP: begin
                ps_new[PS_PEF]  = 1'b1;
                ps_new[PS_AM]   = 1'b0;
                ps_new[PS_IE]   = 1'b0;
                ps_new[PS_CLE]  = 1'b0;
            end
            default: ps_new = ps_old;
        endcase
    end

endmodule

// File: rtl/tsu_hpstate_rewrite.sv
module tsu_hpstate_rewrite
    import tsu_pkg::*;
#(
    parameter int HS_W = 16
) (
    input  trap_kind_e        kind,
    input  logic [HS_W-1:0]   hs_old,
    output logic [HS_W-1:0]   hs_new
);

    always_comb begin
        hs_new = hs_old;
        unique case (kind)
            TK_NONE, TK_PRIV: hs_new = hs_old;
            TK_RED: hs_new[HS_RED] = 1'b1;
            TK_HYP: begin
                hs_new[HS_RED]   = 1'b0;
                hs_new[HS_HPRIV] = 1'b1;
                hs_new[HS_IBE]   = 1'b0;
            end
            default: hs_new = hs_old;
        endcase
    end

endmodule

// File: rtl/tsu_gl_step.sv
module tsu_gl_step #(
    parameter int GL_W   = 3,
    parameter int GL_MAX = 6
) (
    input  logic [GL_W-1:0] gl_old,
    output logic [GL_W-1:0] gl_new
);

    localparam logic [GL_W-1:0] CEIL = GL_W'(GL_MAX);

    // compare before adding so the top code never wraps
    always_comb begin
        if (gl_old >= CEIL) gl_new = CEIL;
        else                gl_new = gl_old + GL_W'(1);
    end

endmodule

// File: rtl/trap_state_unit.sv
module trap_state_unit
    import tsu_pkg::*;
#(
    parameter int PS_W   = 16,
    parameter int HS_W   = 16,
    parameter int GL_W   = 3,
    parameter int GL_MAX = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_en,
    input  logic [PS_W-1:0] load_pstate,
    input  logic [HS_W-1:0] load_hpstate,
    input  logic [GL_W-1:0] load_gl,
    input  logic            trap_take,
    input  logic [1:0]      trap_kind,
    output logic [PS_W-1:0] pstate,
    output logic [HS_W-1:0] hpstate,
    output logic [GL_W-1:0] gl
);

    trap_kind_e      kind;
    logic [PS_W-1:0] ps_trap, ps_next;
    logic [HS_W-1:0] hs_trap, hs_next;
    logic [GL_W-1:0] gl_trap, gl_next;
    logic            real_trap;

    assign kind      = trap_kind_e'(trap_kind);
    assign real_trap = trap_take && (kind != TK_NONE);

    tsu_pstate_rewrite #(.PS_W(PS_W)) u_ps (
        .kind   (kind),
        .ps_old (pstate),
        .ps_new (ps_trap)
    );

    tsu_hpstate_rewrite #(.HS_W(HS_W)) u_hs (
        .kind   (kind),
        .hs_old (hpstate),
        .hs_new (hs_trap)
    );

    tsu_gl_step #(.GL_W(GL_W), .GL_MAX(GL_MAX)) u_gl (
        .gl_old (gl),
        .gl_new (gl_trap)
    );

    // next-state selection: load beats trap, trap beats hold
    always_comb begin
        ps_next = pstate;
        hs_next = hpstate;
        gl_next = gl;
        if (load_en) begin
            ps_next = load_pstate;
            hs_next = load_hpstate;
            gl_next = load_gl;
        end else if (real_trap) begin
            ps_next = ps_trap;
            hs_next = hs_trap;
            gl_next = gl_trap;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pstate  <= '0;
            hpstate <= '0;
            gl      <= '0;
        end else begin
            pstate  <= ps_next;
            hpstate <= hs_next;
            gl      <= gl_next;
        end
    end

endmodule

// File: rtl/tsu_checker.sv
module tsu_checker #(
    parameter int PS_W   = 16,
    parameter int HS_W   = 16,
    parameter int GL_W   = 3,
    parameter int GL_MAX = 6
) (
    input logic            clk,
    input logic            rst,
    input logic            load_en,
    input logic [PS_W-1:0] load_pstate,
    input logic [HS_W-1:0] load_hpstate,
    input logic [GL_W-1:0] load_gl,
    input logic            trap_take,
    input logic [1:0]      trap_kind,
    input logic [PS_W-1:0] pstate,
    input logic [HS_W-1:0] hpstate,
    input logic [GL_W-1:0] gl
);

    localparam logic [GL_W-1:0] CEIL = GL_W'(GL_MAX);
    localparam logic [PS_W-1:0] PS_NORM_MASK = PS_W'(16'h021E);  // bits 9,4,3,2,1
    localparam logic [HS_W-1:0] HS_RED_MASK  = HS_W'(16'h0020);
    localparam logic [HS_W-1:0] HS_HYP_MASK  = HS_W'(16'h0424);

    logic ev_trap, ev_red, ev_priv, ev_hyp, ev_none, ev_idle;
    assign ev_trap = trap_take && !load_en && (trap_kind != 2'b00);
    assign ev_red  = trap_take && !load_en && (trap_kind == 2'b01);
    assign ev_priv = trap_take && !load_en && (trap_kind == 2'b10);
    assign ev_hyp  = trap_take && !load_en && (trap_kind == 2'b11);
    assign ev_none = trap_take && !load_en && (trap_kind == 2'b00);
    assign ev_idle = !trap_take && !load_en;

    a_r2_gl_step: assert property (@(posedge clk) disable iff (rst)
        ev_trap |=> gl == (($past(gl) >= CEIL) ? CEIL : $past(gl) + GL_W'(1)));

    a_r3_red_pstate: assert property (@(posedge clk) disable iff (rst)
        ev_red |=> (pstate[4] == 1'b1) && (pstate[2] == $past(pstate[2]))
                   && ($countones(pstate) == 1 + int'(pstate[2])));

    a_r4_red_hpstate: assert property (@(posedge clk) disable iff (rst)
        ev_red |=> hpstate[5] && ((hpstate & ~HS_RED_MASK) == ($past(hpstate) & ~HS_RED_MASK)));

    a_r5_normal_pstate: assert property (@(posedge clk) disable iff (rst)
        (ev_priv || ev_hyp) |=> pstate[4] && !pstate[3] && !pstate[1]
            && ((pstate & ~PS_NORM_MASK) == ($past(pstate) & ~PS_NORM_MASK)));

    a_r6_hyp_pstate: assert property (@(posedge clk) disable iff (rst)
        ev_hyp |=> !pstate[9] && (pstate[2] == $past(pstate[2])));

    a_r7_hyp_hpstate: assert property (@(posedge clk) disable iff (rst)
        ev_hyp |=> !hpstate[5] && hpstate[2] && !hpstate[10]
            && ((hpstate & ~HS_HYP_MASK) == ($past(hpstate) & ~HS_HYP_MASK)));

    a_r8_priv_state: assert property (@(posedge clk) disable iff (rst)
        ev_priv |=> pstate[2] && (pstate[9] == $past(pstate[8])) && $stable(hpstate));

    a_r9_kind_none: assert property (@(posedge clk) disable iff (rst)
        ev_none |=> $stable(pstate) && $stable(hpstate) && $stable(gl));

    a_r10_load: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (pstate == $past(load_pstate)) && (hpstate == $past(load_hpstate))
                    && (gl == $past(load_gl)));

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        ev_idle |=> $stable(pstate) && $stable(hpstate) && $stable(gl));

endmodule

bind trap_state_unit tsu_checker #(
    .PS_W(PS_W), .HS_W(HS_W), .GL_W(GL_W), .GL_MAX(GL_MAX)
) u_tsu_checker (
    .clk          (clk),
    .rst          (rst),
    .load_en      (load_en),
    .load_pstate  (load_pstate),
    .load_hpstate (load_hpstate),
    .load_gl      (load_gl),
    .trap_take    (trap_take),
    .trap_kind    (trap_kind),
    .pstate       (pstate),
    .hpstate      (hpstate),
    .gl           (gl)
);

// File: tb/trap_state_unit_bench.sv
`timescale 1ns/1ps
module trap_state_unit_bench;

    localparam int GLMAX = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_en = 1'b0;
    logic [15:0] load_pstate = '0;
    logic [15:0] load_hpstate = '0;
    logic [2:0]  load_gl = '0;
    logic        trap_take = 1'b0;
    logic [1:0]  trap_kind = 2'b00;
    logic [15:0] pstate, hpstate;
    logic [2:0]  gl;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;  // 250 MHz

    trap_state_unit u_trap_state_unit (
        .clk(clk), .rst(rst), .load_en(load_en), .load_pstate(load_pstate),
        .load_hpstate(load_hpstate), .load_gl(load_gl), .trap_take(trap_take),
        .trap_kind(trap_kind), .pstate(pstate), .hpstate(hpstate), .gl(gl)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_ps(input logic [15:0] p, input logic [1:0] k);
        logic [15:0] e;
        e = p;
        if (k == 2'b01) begin
            e = 16'h0; e[2] = p[2]; e[4] = 1'b1;
        end else if (k == 2'b10) begin
            e[4] = 1'b1; e[3] = 1'b0; e[1] = 1'b0; e[2] = 1'b1; e[9] = p[8];
        end else if (k == 2'b11) begin
            e[4] = 1'b1; e[3] = 1'b0; e[1] = 1'b0; e[9] = 1'b0;
        end
        return e;
    endfunction

    function automatic logic [15:0] ref_hs(input logic [15:0] h, input logic [1:0] k);
        logic [15:0] e;
        e = h;
        if (k == 2'b01) e[5] = 1'b1;
        else if (k == 2'b11) begin
            e[5] = 1'b0; e[2] = 1'b1; e[10] = 1'b0;
        end
        return e;
    endfunction

    function automatic logic [2:0] ref_gl(input logic [2:0] g, input logic [1:0] k);
        if (k == 2'b00) return g;
        if (int'(g) >= GLMAX) return 3'(GLMAX);
        return g + 3'd1;
    endfunction

    task automatic do_load(input logic [15:0] p, input logic [15:0] h, input logic [2:0] g);
        @(negedge clk);
        load_en = 1'b1; load_pstate = p; load_hpstate = h; load_gl = g;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic do_trap(input logic [1:0] k);
        @(negedge clk);
        trap_take = 1'b1; trap_kind = k;
        @(negedge clk);
        trap_take = 1'b0; trap_kind = 2'b00;
    endtask

    task automatic run_trap(input logic [1:0] k, input string req,
                            input logic [15:0] p, input logic [15:0] h, input logic [2:0] g);
        do_load(p, h, g);
        do_trap(k);
        chk(req, "pstate", 32'(pstate), 32'(ref_ps(p, k)));
        chk(req, "hpstate", 32'(hpstate), 32'(ref_hs(h, k)));
        chk(req, "gl", 32'(gl), 32'(ref_gl(g, k)));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1", "pstate after reset", 32'(pstate), 32'h0);
        chk("R1", "hpstate after reset", 32'(hpstate), 32'h0);
        chk("R1", "gl after reset", 32'(gl), 32'h0);
        do_load(16'hFFFF, 16'hFFFF, 3'd5);
        @(negedge clk);
        rst = 1'b1; load_en = 1'b1; load_pstate = 16'h1234; load_hpstate = 16'h4321; load_gl = 3'd2;
        @(negedge clk);
        rst = 1'b0; load_en = 1'b0;
        chk("R1", "pstate reset over load", 32'(pstate), 32'h0);
        chk("R1", "hpstate reset over load", 32'(hpstate), 32'h0);
        chk("R1", "gl reset over load", 32'(gl), 32'h0);
    endtask

    task automatic t_load();
        do_load(16'hA5C3, 16'h0F0F, 3'd3);
        chk("R10", "pstate loaded", 32'(pstate), 32'hA5C3);
        chk("R10", "hpstate loaded", 32'(hpstate), 32'h0F0F);
        chk("R10", "gl loaded", 32'(gl), 32'd3);
        @(negedge clk);
        load_en = 1'b1; load_pstate = 16'h00FF; load_hpstate = 16'hFF00; load_gl = 3'd1;
        trap_take = 1'b1; trap_kind = 2'b01;
        @(negedge clk);
        load_en = 1'b0; trap_take = 1'b0; trap_kind = 2'b00;
        chk("R10", "pstate load beats trap", 32'(pstate), 32'h00FF);
        chk("R10", "hpstate load beats trap", 32'(hpstate), 32'hFF00);
        chk("R10", "gl load beats trap", 32'(gl), 32'd1);
    endtask

    task automatic t_red();
        run_trap(2'b01, "R3 R4", 16'hFFFF, 16'h0000, 3'd0);
        run_trap(2'b01, "R3 R4", 16'hFFFB, 16'hFFDF, 3'd2);
        for (int i = 0; i < 6; i++)
            run_trap(2'b01, "R3 R4", 16'($urandom), 16'($urandom), 3'($urandom));
    endtask

    task automatic t_priv();
        run_trap(2'b10, "R5 R8", 16'h0100, 16'hAAAA, 3'd1);
        run_trap(2'b10, "R5 R8", 16'hFEFF, 16'h5555, 3'd4);
        for (int i = 0; i < 6; i++)
            run_trap(2'b10, "R5 R8", 16'($urandom), 16'($urandom), 3'($urandom));
    endtask

    task automatic t_hyp();
        run_trap(2'b11, "R5 R6 R7", 16'hFFFF, 16'hFFFF, 3'd0);
        run_trap(2'b11, "R5 R6 R7", 16'h0000, 16'h0000, 3'd3);
        for (int i = 0; i < 6; i++)
            run_trap(2'b11, "R5 R6 R7", 16'($urandom), 16'($urandom), 3'($urandom));
    endtask

    task automatic t_none();
        run_trap(2'b00, "R9", 16'h5A5A, 16'hA5A5, 3'd4);
    endtask

    task automatic t_gl_sat();
        do_load(16'h0, 16'h0, 3'(GLMAX - 1));
        do_trap(2'b10);
        chk("R2", "gl reaches ceiling", 32'(gl), 32'(GLMAX));
        do_trap(2'b11);
        chk("R2", "gl stays at ceiling", 32'(gl), 32'(GLMAX));
        do_load(16'h0, 16'h0, 3'd7);
        do_trap(2'b01);
        chk("R2", "gl above ceiling clamps", 32'(gl), 32'(GLMAX));
    endtask

    task automatic t_hold();
        do_load(16'hC3A5, 16'h3C5A, 3'd2);
        repeat (4) @(negedge clk);
        chk("R11", "pstate held", 32'(pstate), 32'hC3A5);
        chk("R11", "hpstate held", 32'(hpstate), 32'h3C5A);
        chk("R11", "gl held", 32'(gl), 32'd2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_load();
        t_red();
        t_priv();
        t_hyp();
        t_none();
        t_gl_sat();
        t_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule